// File: doc/BRIEF.md
# QoS Priority Arbiter

This block picks one of N requesting master ports at a time to reach a single shared downstream target. Every request carries a 4-bit service-class code. A per-port table turns that code into one of 16 common internal levels, and the highest level pending always wins. Ports that tie at the top level share the target by weighted round-robin, using a credit budget that is programmed for each port.

The arbiter tracks how long each pending request has waited. A request that has waited past a programmable promotion threshold competes one level higher. A request that has waited past a programmable timeout sets a sticky error interrupt, which stays set until software clears it. Software programs the tables, weights and limits through a simple write-only register port. Writes are accepted only while no grant is outstanding.

A grant is registered and offered downstream with the winning port number. It is held until the target accepts it. In the cycle of acceptance, the matching master sees its ready signal.

Top module: `qos_prio_arb`

## Requirements
- R1: After a synchronous reset the block is in a defined state. `dn_valid`, `err_irq` and all `req_ready` bits are 0. Every port maps code q to level q. Every weight code is 0. The promotion threshold and the timeout limit are all-ones.
- R2: A write with `cfg_addr` = {2'b00, port, code} stores `cfg_wdata[3:0]` as the internal level of that port's code. Later arbitration uses the stored level.
- R3: A pending request whose effective level is higher wins over every request at a lower level, whatever the port order and the pointer.
- R4: A write with `cfg_addr` = {2'b01, port, 4'hx} stores a weight code w from `cfg_wdata[WT_W-1:0]`. Among the ports tied at the top level, each port receives up to w+1 grants per round. Each grant uses one credit. When none of the tied ports has credit left, all of them are refilled.
- R5: After a grant to port p, the search for the next winner starts at port p+1 and wraps at N. As a result, tied ports with equal weights alternate.
- R6: At most one grant is outstanding. While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` and `dn_port` hold. `req_ready[p]` is 1 only in a cycle where `dn_valid` and `dn_ready` are both 1 and `dn_port` = p. The next grant appears no earlier than the cycle after that handshake.
- R7: A port's wait counter counts the cycles in which its request is pending and not granted. The counter clears on grant and when the request is withdrawn. Once the count reaches the threshold set by the write {2'b10, x, 4'h0}, the port competes one level higher, up to a limit of level 15.
- R8: Once any pending, ungranted port's wait count reaches the limit set by the write {2'b10, x, 4'h1}, `err_irq` goes to 1 and stays at 1 after the request is served.
- R9: The write {2'b10, x, 4'h2} clears `err_irq` one cycle after the write edge. Any configuration write made while a grant is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Request pending, one bit per port |
| req_qos | input | 4*N | Service-class code per port, port p at bits [4p+3:4p] |
| req_ready | output | N | Request accepted downstream, one bit per port |
| dn_valid | output | 1 | Grant offered to the target |
| dn_port | output | PW | Index of the granted port |
| dn_ready | input | 1 | Target accepts the offered grant |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2+PW+4 | {select, port, index} |
| cfg_wdata | input | AGE_W | Configuration write data |
| err_irq | output | 1 | Sticky wait-timeout interrupt |

## Verification
The bench builds the arbiter with four ports, 8-bit wait counters and 3-bit weight codes. With four ports, the round-robin pointer can wrap and can skip idle ports. With 8-bit counters, promotion and timeout thresholds of three to five cycles can be reached within a few grants. A weight code of 2 against a weight code of 0 produces a 3:1 interleave, including a refill in the middle of a burst. Holding `dn_ready` low keeps a grant outstanding. This lets the bench push a waiting port past its timeout and try a configuration write while the arbiter is busy.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int QOS_W = 4;
  localparam int NQ    = 1 << QOS_W;
  localparam int LVL_W = 4;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    CFG_MAP = 2'd0,
    CFG_WGT = 2'd1,
    CFG_CTL = 2'd2,
    CFG_RSV = 2'd3
  } cfg_sel_e;

  localparam logic [QOS_W-1:0] CTL_PROMOTE = 4'd0;
  localparam logic [QOS_W-1:0] CTL_TIMEOUT = 4'd1;
  localparam logic [QOS_W-1:0] CTL_CLR_ERR = 4'd2;
endpackage

// File: rtl/qos_cfg_regs.sv
module qos_cfg_regs
  import qos_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int PW    = 2,
  parameter int WT_W  = 3,
  parameter int AGE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [2+PW+QOS_W-1:0]      cfg_addr,
  input  logic [AGE_W-1:0]           cfg_wdata,
  input  logic                       busy,
  output logic [N*NQ*LVL_W-1:0]      map_flat,
  output logic [N*WT_W-1:0]          wgt_flat,
  output logic [AGE_W-1:0]           promote_thr,
  output logic [AGE_W-1:0]           timeout_lim,
  output logic                       clr_err
);
  localparam int CAW = 2 + PW + QOS_W;
  localparam int ENT = N * NQ;

  lvl_t             map_q [ENT];
  logic [WT_W-1:0]  wgt_q [N];

  cfg_sel_e         sel;
  logic [PW-1:0]    port;
  logic [QOS_W-1:0] idx;
  logic             port_ok;
  logic             wr;

  assign sel     = cfg_sel_e'(cfg_addr[CAW-1 -: 2]);
  assign port    = cfg_addr[QOS_W +: PW];
  assign idx     = cfg_addr[QOS_W-1:0];
  assign port_ok = int'(port) < N;
  assign wr      = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENT; e++) map_q[e] <= lvl_t'(e % NQ);
      for (int p = 0; p < N; p++)   wgt_q[p] <= '0;
      promote_thr <= '1;
      timeout_lim <= '1;
      clr_err     <= 1'b0;
    end else begin
      clr_err <= 1'b0;
      if (wr) begin
        unique case (sel)
          CFG_MAP: if (port_ok) map_q[int'(port)*NQ + int'(idx)] <= cfg_wdata[LVL_W-1:0];
          CFG_WGT: if (port_ok) wgt_q[int'(port)] <= cfg_wdata[WT_W-1:0];
          CFG_CTL: begin
            if (idx == CTL_PROMOTE) promote_thr <= cfg_wdata;
            if (idx == CTL_TIMEOUT) timeout_lim <= cfg_wdata;
            if (idx == CTL_CLR_ERR) clr_err     <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  generate
    for (genvar ge = 0; ge < ENT; ge++) begin : g_map
      assign map_flat[ge*LVL_W +: LVL_W] = map_q[ge];
    end
    for (genvar gp = 0; gp < N; gp++) begin : g_wgt
      assign wgt_flat[gp*WT_W +: WT_W] = wgt_q[gp];
    end
  endgenerate

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(wgt_flat) && $stable(promote_thr) && $stable(timeout_lim) && !clr_err));
endmodule

// File: rtl/qos_age_track.sv
module qos_age_track #(
  parameter int N     = 4,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_valid,
  input  logic [N-1:0]     held,
  input  logic [N-1:0]     issue,
  input  logic [AGE_W-1:0] promote_thr,
  input  logic [AGE_W-1:0] timeout_lim,
  output logic [N-1:0]     promote,
  output logic [N-1:0]     expired
);
  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_port
      logic [AGE_W-1:0] age_q;

      always_ff @(posedge clk) begin
        if (rst || issue[gi] || !req_valid[gi]) age_q <= '0;
        else if (!held[gi] && age_q != '1)       age_q <= age_q + 1'b1;
      end

      assign promote[gi] = req_valid[gi] && (age_q >= promote_thr);
      assign expired[gi] = req_valid[gi] && !held[gi] && (age_q >= timeout_lim);

      // R7
      age_clear_chk: assert property (@(posedge clk) disable iff (rst)
        issue[gi] |=> (age_q == '0));
    end
  endgenerate
endmodule

// File: rtl/qos_prio_stage.sv
module qos_prio_stage
  import qos_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]          req_valid,
  input  logic [N*QOS_W-1:0]    req_qos,
  input  logic [N*NQ*LVL_W-1:0] map_flat,
  input  logic [N-1:0]          promote,
  output logic [N-1:0]          cand
);
  lvl_t eff [N];
  lvl_t top_lvl;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_eff
      lvl_t raw;
      assign raw     = map_flat[(gi*NQ + int'(req_qos[gi*QOS_W +: QOS_W]))*LVL_W +: LVL_W];
      assign eff[gi] = (promote[gi] && raw != LVL_TOP) ? lvl_t'(raw + 1'b1) : raw;
    end
  endgenerate

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && eff[i] > top_lvl) top_lvl = eff[i];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) cand[i] = req_valid[i] && (eff[i] == top_lvl);
  end
endmodule

// File: rtl/qos_wrr_pick.sv
module qos_wrr_pick #(
  parameter int N    = 4,
  parameter int WT_W = 3,
  parameter int PW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    cand,
  input  logic [N*WT_W-1:0] wgt_flat,
  input  logic            advance,
  output logic [PW-1:0]   win_idx,
  output logic            win_any
);
  localparam int CW = WT_W + 1;

  logic [CW-1:0] credit_q [N];
  logic [PW-1:0] ptr_q;
  logic [N-1:0]  elig;
  logic [N-1:0]  pool;
  logic          reload;

  always_comb begin
    for (int i = 0; i < N; i++) elig[i] = cand[i] && (credit_q[i] != '0);
    reload = (elig == '0);
    pool   = reload ? cand : elig;
    win_idx = '0;
    win_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (pool[j] && !win_any) begin
        win_any = 1'b1;
        win_idx = PW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) credit_q[i] <= '0;
      ptr_q <= '0;
    end else if (advance && win_any) begin
      for (int i = 0; i < N; i++) begin
        if (reload && cand[i])
          credit_q[i] <= CW'(wgt_flat[i*WT_W +: WT_W]) + ((i == int'(win_idx)) ? CW'(0) : CW'(1));
        else if (i == int'(win_idx))
          credit_q[i] <= credit_q[i] - 1'b1;
      end
      ptr_q <= (int'(win_idx) == N-1) ? '0 : PW'(win_idx + 1'b1);
    end
  end

  // R4
  winner_is_candidate_chk: assert property (@(posedge clk) disable iff (rst)
    win_any |-> cand[win_idx]);
endmodule

// File: rtl/qos_prio_arb.sv
module qos_prio_arb
  import qos_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int WT_W  = 3,
  parameter int AGE_W = 8,
  localparam int PW   = (N > 1) ? $clog2(N) : 1,
  localparam int CAW  = 2 + PW + QOS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       req_valid,
  input  logic [N*QOS_W-1:0] req_qos,
  output logic [N-1:0]       req_ready,
  output logic               dn_valid,
  output logic [PW-1:0]      dn_port,
  input  logic               dn_ready,
  input  logic               cfg_we,
  input  logic [CAW-1:0]     cfg_addr,
  input  logic [AGE_W-1:0]   cfg_wdata,
  output logic               err_irq
);
  logic [N*NQ*LVL_W-1:0] map_flat;
  logic [N*WT_W-1:0]     wgt_flat;
  logic [AGE_W-1:0]      promote_thr;
  logic [AGE_W-1:0]      timeout_lim;
  logic                  clr_err;
  logic [N-1:0]          promote;
  logic [N-1:0]          expired;
  logic [N-1:0]          cand;
  logic [N-1:0]          held;
  logic [N-1:0]          issue;
  logic [PW-1:0]         win_idx;
  logic                  win_any;
  logic                  issue_en;
  logic                  gnt_q;
  logic [PW-1:0]         gnt_port_q;
  logic                  irq_q;

  qos_cfg_regs #(.N(N), .PW(PW), .WT_W(WT_W), .AGE_W(AGE_W)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(gnt_q), .map_flat(map_flat), .wgt_flat(wgt_flat),
    .promote_thr(promote_thr), .timeout_lim(timeout_lim), .clr_err(clr_err)
  );

  qos_age_track #(.N(N), .AGE_W(AGE_W)) age_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .held(held), .issue(issue),
    .promote_thr(promote_thr), .timeout_lim(timeout_lim),
    .promote(promote), .expired(expired)
  );

  qos_prio_stage #(.N(N)) prio_i (
    .req_valid(req_valid), .req_qos(req_qos), .map_flat(map_flat),
    .promote(promote), .cand(cand)
  );

  qos_wrr_pick #(.N(N), .WT_W(WT_W), .PW(PW)) wrr_i (
    .clk(clk), .rst(rst), .cand(cand), .wgt_flat(wgt_flat), .advance(issue_en),
    .win_idx(win_idx), .win_any(win_any)
  );

  assign issue_en = !gnt_q && win_any;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      held[i]  = gnt_q && (int'(gnt_port_q) == i);
      issue[i] = issue_en && (int'(win_idx) == i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q      <= 1'b0;
      gnt_port_q <= '0;
    end else if (gnt_q) begin
      if (dn_ready) gnt_q <= 1'b0;
    end else if (issue_en) begin
      gnt_q      <= 1'b1;
      gnt_port_q <= win_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             irq_q <= 1'b0;
    else if (|expired)   irq_q <= 1'b1;
    else if (clr_err)    irq_q <= 1'b0;
  end

  assign req_ready = held & {N{dn_ready}};
  assign dn_valid  = gnt_q;
  assign dn_port   = gnt_port_q;
  assign err_irq   = irq_q;

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_port)));
  // R6
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready) && ((req_ready != '0) -> (dn_valid && dn_ready)));
  // R6
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_ready) |=> !dn_valid);
  // R3
  grant_from_pending_chk: assert property (@(posedge clk) disable iff (rst)
    issue_en |-> req_valid[win_idx]);
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_irq) |-> $past(clr_err));
endmodule

// File: tb/qos_prio_arb_tb_top.sv
module qos_prio_arb_tb_top;
  localparam int N = 4, PW = 2, WT_W = 3, AGE_W = 8, CAW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   req_valid;
  logic [N*4-1:0] req_qos = '0;
  logic [N-1:0]   req_ready;
  logic           dn_valid;
  logic [PW-1:0]  dn_port;
  logic           dn_ready = 1'b1;
  logic           cfg_we = 1'b0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [AGE_W-1:0] cfg_wdata = '0;
  logic           err_irq;

  int txn_total [N] = '{default: 0};
  int txn_done  [N] = '{default: 0};
  int    exp_port [$];
  string exp_tag  [$];
  int mon_rd = 0, mon_checks = 0, mon_fails = 0;
  int drv_checks = 0, drv_fails = 0, wd_fail = 0;

  always #2 clk = ~clk;

  qos_prio_arb #(.N(N), .WT_W(WT_W), .AGE_W(AGE_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_qos(req_qos), .req_ready(req_ready),
    .dn_valid(dn_valid), .dn_port(dn_port), .dn_ready(dn_ready),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .err_irq(err_irq)
  );

  always_comb begin
    for (int i = 0; i < N; i++) req_valid[i] = txn_done[i] < txn_total[i];
  end

  // masters: one transaction retires per observed ready
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) if (req_ready[i]) txn_done[i] = txn_done[i] + 1;
  end

  // monitor: compare each accepted grant with the scoreboard
  always @(negedge clk) begin
    if (!rst && dn_valid && dn_ready) begin
      mon_checks++;
      if (mon_rd >= exp_port.size()) begin
        mon_fails++;
        $display("FAIL R3: grant to port %0d, expected none", dn_port);
      end else begin
        if (int'(dn_port) != exp_port[mon_rd]) begin
          mon_fails++;
          $display("FAIL %s: grant to port %0d, expected port %0d", exp_tag[mon_rd], dn_port, exp_port[mon_rd]);
        end
        mon_rd++;
      end
    end
  end

  task automatic print_summary();
    $display("== %0d vectors applied, %0d miscompares ==",
             drv_checks + mon_checks + wd_fail, drv_fails + mon_fails + wd_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL R6: watchdog expired, got 0 expected 1 completion");
    print_summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    drv_checks++;
    if (!ok) begin
      drv_fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic drv_at();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    drv_at();
    rst = 1'b1; dn_ready = 1'b1; cfg_we = 1'b0;
    repeat (3) drv_at();
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int port, input int idx, input int data);
    drv_at();
    cfg_we = 1'b1; cfg_addr = {sel, 2'(port), 4'(idx)}; cfg_wdata = AGE_W'(data);
    drv_at();
    cfg_we = 1'b0;
  endtask

  task automatic set_qos(input int p, input int q);
    req_qos[p*4 +: 4] = 4'(q);
  endtask

  task automatic expect_seq(input int ports [$], input string tag);
    foreach (ports[k]) begin
      exp_port.push_back(ports[k]);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic wait_drain(input string tag);
    int guard = 0;
    while (mon_rd < exp_port.size() && guard < 500) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    check(mon_rd == exp_port.size(), tag, mon_rd, exp_port.size());
    check(req_valid == '0, tag, int'(req_valid), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(dn_valid == 1'b0, "R1", int'(dn_valid), 0);
    check(err_irq == 1'b0, "R1", int'(err_irq), 0);
    check(req_ready == '0, "R1", int'(req_ready), 0);

    // R3: strict level order with identity mapping
    set_qos(0, 2); set_qos(1, 5); set_qos(2, 5); set_qos(3, 1);
    expect_seq('{1, 2, 0, 3}, "R3");
    drv_at();
    for (int i = 0; i < N; i++) txn_total[i] += 1;
    wait_drain("R3");

    // R2: port 3 code 1 remapped to level 9
    do_reset();
    cfg_write(2'd0, 3, 1, 9);
    expect_seq('{3, 1, 2, 0}, "R2");
    drv_at();
    for (int i = 0; i < N; i++) txn_total[i] += 1;
    wait_drain("R2");

    // R4: weight code 2 on port 0 against code 0 on port 1
    do_reset();
    cfg_write(2'd1, 0, 0, 2);
    set_qos(0, 4); set_qos(1, 4); set_qos(2, 0); set_qos(3, 0);
    expect_seq('{0, 1, 0, 0, 1, 0, 0, 0, 1, 1, 1, 1}, "R4");
    drv_at();
    txn_total[0] += 6; txn_total[1] += 6;
    wait_drain("R4");

    // R5: equal weights alternate, pointer skips idle ports
    do_reset();
    set_qos(1, 7); set_qos(3, 7);
    expect_seq('{1, 3, 1, 3, 1, 3}, "R5");
    drv_at();
    txn_total[1] += 3; txn_total[3] += 3;
    wait_drain("R5");

    // R7 control: no promotion with default threshold
    do_reset();
    set_qos(0, 2); set_qos(1, 3);
    expect_seq('{1, 1, 1, 1, 0}, "R7");
    drv_at();
    txn_total[0] += 1; txn_total[1] += 4;
    wait_drain("R7");

    // R7: threshold 3 lifts port 0 into a tie at level 3
    do_reset();
    cfg_write(2'd2, 0, 0, 3);
    expect_seq('{1, 1, 0, 1, 1}, "R7");
    drv_at();
    txn_total[0] += 1; txn_total[1] += 4;
    wait_drain("R7");

    // R6/R8/R9: stalled grant, timeout, busy write, clear
    do_reset();
    cfg_write(2'd2, 0, 1, 5);
    set_qos(0, 1); set_qos(1, 9);
    expect_seq('{1, 0}, "R6");
    drv_at();
    dn_ready = 1'b0;
    txn_total[0] += 1; txn_total[1] += 1;
    repeat (3) @(negedge clk);
    check(err_irq == 1'b0, "R8", int'(err_irq), 0);
    check(dn_valid == 1'b1, "R6", int'(dn_valid), 1);
    check(dn_port == 2'd1, "R6", int'(dn_port), 1);
    check(req_ready == '0, "R6", int'(req_ready), 0);
    repeat (10) @(negedge clk);
    check(err_irq == 1'b1, "R8", int'(err_irq), 1);
    check(dn_valid == 1'b1 && dn_port == 2'd1, "R6", int'(dn_port), 1);
    cfg_write(2'd2, 0, 2, 0);
    repeat (3) @(negedge clk);
    check(err_irq == 1'b1, "R9", int'(err_irq), 1);
    drv_at();
    dn_ready = 1'b1;
    wait_drain("R6");
    check(err_irq == 1'b1, "R8", int'(err_irq), 1);
    cfg_write(2'd2, 0, 2, 0);
    repeat (2) @(negedge clk);
    check(err_irq == 1'b0, "R9", int'(err_irq), 0);

    print_summary();
    $finish;
  end
endmodule